// File: doc/BRIEF.md
# Fractional-Increment System Time Counter

This block keeps a free-running 64-bit system time value that advances on every edge of its reference clock by a programmable fixed-point increment. The increment is chosen so that the clock period, scaled by a power of two, is what gets added each tick. Software recovers nanoseconds by shifting the count right by that power of two. The increment and the shift depend on the link rate. At 6.4 ns per tick a typical increment is 0x66666666 with a shift of 28. At 64 ns it is 0x40000000 with a shift of 24, and at 640 ns it is 0x50000000 with a shift of 21. Software trims the frequency by rewriting the increment while the count keeps running.

A small register port reads and writes the time as two 32-bit words and programs the increment. Reading the low word captures the high word in a shadow, so the following high read stays coherent across a carry. Writing the low word only stages it. The time is loaded as a whole when the high word is written.

A parameter selects one of two increment formats. The wide format has a 31-bit increment added on every tick. The narrow format has a 24-bit increment plus an 8-bit period field, and adds the increment once every N ticks. A one-cycle pulse flags each overflow of the 64-bit sum.

Top module: `ptc_timer`

## Requirements
- R1: In the wide variant, the increment register holds a 31-bit value in bits [30:0]. Bit 31 reads as zero and never contributes. The time value grows by that value on every clock edge that carries no time load.
- R2: In the narrow variant, bits [23:0] hold the increment and bits [31:24] hold a period N. The increment is added once every N edges. The period counter restarts on an increment write and on a time load. N = 0 stops the count.
- R3: When an addition carries out of bit 63, `wrap_pulse` is high for exactly the one cycle after that edge. A time load never raises it.
- R4: A zero increment leaves the time value unchanged from edge to edge.
- R5: A write to address 0 (low word) only stages the data and leaves the time value untouched. A write to address 1 (high word) loads {high, staged low} on that edge, with no increment applied on that edge. Writing zeros to both words clears the time.
- R6: A read is answered on `bus_rdata` in the cycle after the strobe, and the value holds until the next read. A low-word read (address 0) returns bits [31:0] and snapshots bits [63:32]. A high-word read (address 1) returns that snapshot.
- R7: An increment write (address 2) takes effect from the next edge on. The time value is not reset or disturbed. The edge of the write itself still uses the old increment.
- R8: After reset the time is 0, `wrap_pulse` and `bus_rdata` are 0, and the increment reads 0x66666666 (wide) or 0x01CCCCCC (narrow: the default shifted right by 7, period 1).
- R9: Address 3 is reserved. It reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every edge is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 time low, 1 time high, 2 increment, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| wrap_pulse | output | 1 | One-cycle overflow indication |

## Verification
The bench counts clock edges itself and predicts every read as the loaded time plus the increment multiplied by the number of additions since the load. That prediction also covers the floor of edges divided by the period in the narrow variant. A design that added on the load edge, or applied a new increment one edge early or late, would drift by exactly one step.

A carry across the word boundary between a low read and a high read exposes a missing shadow, which would return a high word one too large. A load near the top of the range checks that the wrap pulse appears exactly once, on the right cycle.

Bit 31 of the wide increment, the reserved address and a lone low-word write are each checked at the read port. A design that let any of them through would give a read value that differs by a large, easily seen amount.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

   typedef enum logic [1:0] {
      REG_TIME_LO = 2'd0,
      REG_TIME_HI = 2'd1,
      REG_INCR    = 2'd2,
      REG_SPARE   = 2'd3
   } ptc_reg_e;

   typedef struct packed {
      logic wr_lo;
      logic wr_hi;
      logic wr_inc;
      logic rd_lo;
      logic rd_hi;
      logic rd_inc;
   } ptc_strobe_t;

endpackage

// File: rtl/ptc_regif.sv
module ptc_regif
   import ptc_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [TIME_W-1:0] time_q,
   input  logic [BUS_W-1:0]  inc_rd,
   output logic [BUS_W-1:0]  rdata,
   output logic              load,
   output logic [TIME_W-1:0] load_val,
   output logic              inc_wr
);

   ptc_strobe_t      stb;
   logic [BUS_W-1:0] stage_lo_q;
   logic [BUS_W-1:0] shadow_hi_q;

   always_comb begin
      stb        = '0;
      stb.wr_lo  = wr_en && (addr == REG_TIME_LO);
      stb.wr_hi  = wr_en && (addr == REG_TIME_HI);
      stb.wr_inc = wr_en && (addr == REG_INCR);
      stb.rd_lo  = rd_en && (addr == REG_TIME_LO);
      stb.rd_hi  = rd_en && (addr == REG_TIME_HI);
      stb.rd_inc = rd_en && (addr == REG_INCR);
   end

   assign load     = stb.wr_hi;
   assign load_val = {wdata, stage_lo_q};
   assign inc_wr   = stb.wr_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_lo_q  <= '0;
         shadow_hi_q <= '0;
         rdata       <= '0;
      end else begin
         if (stb.wr_lo) stage_lo_q <= wdata;
         if (stb.rd_lo) shadow_hi_q <= time_q[TIME_W-1:BUS_W];
         if (rd_en) begin
            if (stb.rd_lo)       rdata <= time_q[BUS_W-1:0];
            else if (stb.rd_hi)  rdata <= shadow_hi_q;
            else if (stb.rd_inc) rdata <= inc_rd;
            else                 rdata <= '0;
         end
      end
   end

   // R6: the low read captures the upper half of the time seen at that edge
   p_shadow_capture_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      stb.rd_lo |=> shadow_hi_q == $past(time_q[TIME_W-1:BUS_W]));

   // R6: read data holds between read strobes
   p_rdata_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   // R9: the spare address answers zero
   p_spare_zero_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == REG_SPARE) |=> rdata == '0);

endmodule

// File: rtl/ptc_incgen.sv
module ptc_incgen #(
   parameter int              BUS_W     = 32,
   parameter int              TIME_W    = 64,
   parameter bit              NARROW    = 1'b0,
   parameter int              NAR_VAL_W = 24,
   parameter int              NAR_SHIFT = 7,
   parameter logic [BUS_W-1:0] INC_INIT = 32'h6666_6666
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_wr,
   input  logic [BUS_W-1:0]  inc_wdata,
   input  logic              load,
   output logic [TIME_W-1:0] addend,
   output logic [BUS_W-1:0]  inc_rd
);

   localparam int WIDE_VAL_W = BUS_W - 1;
   localparam int PER_W      = BUS_W - NAR_VAL_W;

   if (NAR_VAL_W >= BUS_W || NAR_VAL_W < 1) begin : g_bad_narrow
      $error("ptc_incgen: narrow increment field must be narrower than the bus");
   end

   if (NARROW) begin : g_narrow
      localparam logic [NAR_VAL_W-1:0] VAL_RST = NAR_VAL_W'(INC_INIT >> NAR_SHIFT);
      localparam logic [PER_W-1:0]     PER_RST = PER_W'(1);

      logic [NAR_VAL_W-1:0] val_q;
      logic [PER_W-1:0]     per_q;
      logic [PER_W-1:0]     cnt_q;
      logic                 tick;

      assign tick   = (per_q != '0) && (cnt_q == per_q - PER_W'(1));
      assign addend = tick ? TIME_W'(val_q) : '0;
      assign inc_rd = {per_q, val_q};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= VAL_RST;
            per_q <= PER_RST;
            cnt_q <= '0;
         end else begin
            if (inc_wr) begin
               val_q <= inc_wdata[NAR_VAL_W-1:0];
               per_q <= inc_wdata[BUS_W-1:NAR_VAL_W];
            end
            if (inc_wr || load || tick || per_q == '0) cnt_q <= '0;
            else                                       cnt_q <= cnt_q + PER_W'(1);
         end
      end

      // R2: with a period above one, two adding edges never follow each other
      p_tick_gap_r2 : assert property (@(posedge clk) disable iff (!rst_n)
         (tick && per_q > PER_W'(1) && !inc_wr && !load) |=> !tick);

      // R2: a period of zero never produces an addend
      p_period_zero_r2 : assert property (@(posedge clk) disable iff (!rst_n)
         (per_q == '0 && !inc_wr) |=> addend == '0);
   end else begin : g_wide
      localparam logic [WIDE_VAL_W-1:0] VAL_RST = WIDE_VAL_W'(INC_INIT);

      logic [WIDE_VAL_W-1:0] val_q;

      assign addend = TIME_W'(val_q);
      assign inc_rd = {1'b0, val_q};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      val_q <= VAL_RST;
         else if (inc_wr) val_q <= inc_wdata[WIDE_VAL_W-1:0];
      end

      // R7: an increment write shows up as the new addend on the next edge
      p_retune_r7 : assert property (@(posedge clk) disable iff (!rst_n)
         inc_wr |=> addend == TIME_W'($past(inc_wdata[WIDE_VAL_W-1:0])));
   end

endmodule

// File: rtl/ptc_accum.sv
module ptc_accum #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TIME_W-1:0] load_val,
   input  logic [TIME_W-1:0] addend,
   output logic [TIME_W-1:0] time_q,
   output logic              wrap
);

   logic [TIME_W:0] sum;

   assign sum = {1'b0, time_q} + {1'b0, addend};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         time_q <= '0;
         wrap   <= 1'b0;
      end else if (load) begin
         time_q <= load_val;
         wrap   <= 1'b0;
      end else begin
         time_q <= sum[TIME_W-1:0];
         wrap   <= sum[TIME_W];
      end
   end

   // R1: without a load the time steps by the addend offered on that edge
   p_step_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> time_q == $past(time_q) + $past(addend));

   // R5: a load lands exactly, no increment and no wrap
   p_load_exact_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (time_q == $past(load_val)) && !wrap);

   // R4: a zero addend freezes the count
   p_freeze_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && addend == '0) |=> $stable(time_q));

   // R3: the wrap flag lasts one cycle and marks a drop in value
   p_wrap_single_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> !wrap);

   p_wrap_drop_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wrap) |-> time_q < $past(time_q));

endmodule

// File: rtl/ptc_timer.sv
module ptc_timer #(
   parameter int               BUS_W     = 32,
   parameter int               TIME_W    = 64,
   parameter bit               NARROW    = 1'b0,
   parameter int               NAR_VAL_W = 24,
   parameter int               NAR_SHIFT = 7,
   parameter logic [BUS_W-1:0] INC_INIT  = 32'h6666_6666
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             wrap_pulse
);

   if (TIME_W != 2 * BUS_W) begin : g_bad_width
      $error("ptc_timer: time width must be two bus words");
   end

   logic              load;
   logic [TIME_W-1:0] load_val;
   logic              inc_wr;
   logic [TIME_W-1:0] addend;
   logic [BUS_W-1:0]  inc_rd;
   logic [TIME_W-1:0] time_q;

   ptc_regif #(.BUS_W(BUS_W), .TIME_W(TIME_W)) u_regif (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .rd_en    (bus_rd),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .time_q   (time_q),
      .inc_rd   (inc_rd),
      .rdata    (bus_rdata),
      .load     (load),
      .load_val (load_val),
      .inc_wr   (inc_wr)
   );

   ptc_incgen #(
      .BUS_W     (BUS_W),
      .TIME_W    (TIME_W),
      .NARROW    (NARROW),
      .NAR_VAL_W (NAR_VAL_W),
      .NAR_SHIFT (NAR_SHIFT),
      .INC_INIT  (INC_INIT)
   ) u_incgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_wr    (inc_wr),
      .inc_wdata (bus_wdata),
      .load      (load),
      .addend    (addend),
      .inc_rd    (inc_rd)
   );

   ptc_accum #(.TIME_W(TIME_W)) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .addend   (addend),
      .time_q   (time_q),
      .wrap     (wrap_pulse)
   );

   // R8: the wrap pulse stays low in the first cycle out of reset
   p_reset_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !wrap_pulse);

endmodule

// File: tb/sim_ptc_timer.sv
module sim_ptc_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr0 = 1'b0, wr1 = 1'b0, rd0 = 1'b0, rd1 = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata0, rdata1;
   logic        wrap0, wrap1;

   int total = 0;
   int bad = 0;
   int ticks = 0;
   int wcnt = 0;
   int wtick = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) ticks <= ticks + 1;
   always @(negedge clk) if (wrap0) begin wcnt++; wtick = ticks; end

   ptc_timer #(.NARROW(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr0), .bus_rd(rd0), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata0), .wrap_pulse(wrap0));

   ptc_timer #(.NARROW(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr1), .bus_rd(rd1), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata1), .wrap_pulse(wrap1));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bwr(input int u, input logic [1:0] a, input logic [31:0] d, output int e);
      addr = a; wdata = d;
      if (u == 0) wr0 = 1'b1; else wr1 = 1'b1;
      @(negedge clk);
      wr0 = 1'b0; wr1 = 1'b0;
      e = ticks;
   endtask

   task automatic brd(input int u, input logic [1:0] a, output logic [31:0] d, output int e);
      addr = a;
      if (u == 0) rd0 = 1'b1; else rd1 = 1'b1;
      @(negedge clk);
      rd0 = 1'b0; rd1 = 1'b0;
      d = (u == 0) ? rdata0 : rdata1;
      e = ticks;
   endtask

   function automatic logic [63:0] tadd(input logic [63:0] t, input logic [63:0] inc, input int k);
      return t + inc * 64'(k);
   endfunction

   initial begin
      repeat (3000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int ref0, e, l, i, i2, r, r2, x;
      logic [31:0] d;
      logic [63:0] exp, t;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      ref0 = ticks;

      // R8 reset state
      chk("R8 wrap wide", 64'(wrap0), 0);
      chk("R8 wrap narrow", 64'(wrap1), 0);
      chk("R8 rdata wide", 64'(rdata0), 0);
      chk("R8 rdata narrow", 64'(rdata1), 0);
      brd(0, 2'd2, d, e); chk("R8 wide increment default", 64'(d), 64'h6666_6666);
      brd(1, 2'd2, d, e); chk("R8 narrow increment default", 64'(d), 64'h01CC_CCCC);

      // R1 running from reset with the default increment
      brd(0, 2'd0, d, r);
      exp = tadd(0, 64'h6666_6666, r - ref0 - 1);
      chk("R1 wide low from reset", 64'(d), 64'(exp[31:0]));
      brd(0, 2'd1, d, e);
      chk("R1 wide high from reset", 64'(d), 64'(exp[63:32]));
      brd(1, 2'd0, d, r);
      exp = tadd(0, 64'h00CC_CCCC, r - ref0 - 1);
      chk("R2 narrow low from reset", 64'(d), 64'(exp[31:0]));

      // R5 load exact, no increment on the load edge
      t = 64'h1234_5678_9ABC_DEF0;
      bwr(0, 2'd0, t[31:0], x);
      bwr(0, 2'd1, t[63:32], l);
      brd(0, 2'd0, d, r); chk("R5 load low exact", 64'(d), 64'(t[31:0]));
      brd(0, 2'd1, d, e); chk("R5 load high exact", 64'(d), 64'(t[63:32]));

      // R5 a lone low write leaves the time alone
      repeat (3) @(negedge clk);
      bwr(0, 2'd0, 32'hDEAD_BEEF, x);
      brd(0, 2'd0, d, r);
      exp = tadd(t, 64'h6666_6666, r - l - 1);
      chk("R5 lone low write ignored", 64'(d), 64'(exp[31:0]));
      brd(0, 2'd1, d, e);
      chk("R5 lone low write high", 64'(d), 64'(exp[63:32]));

      // R6 carry between the two reads
      bwr(0, 2'd2, 32'h10, i);
      bwr(0, 2'd0, 32'hFFFF_FFF0, x);
      bwr(0, 2'd1, 32'h5, l);
      brd(0, 2'd0, d, r); chk("R6 low before carry", 64'(d), 64'hFFFF_FFF0);
      brd(0, 2'd1, d, e); chk("R6 high coherent across carry", 64'(d), 64'h5);

      // R3 wrap pulse
      wcnt = 0;
      t = 64'hFFFF_FFFF_FFFF_FFE8;
      bwr(0, 2'd0, t[31:0], x);
      bwr(0, 2'd1, t[63:32], l);
      repeat (5) @(negedge clk);
      chk("R3 one wrap pulse", 64'(wcnt), 1);
      chk("R3 wrap pulse cycle", 64'(wtick), 64'(l + 2));
      brd(0, 2'd0, d, r);
      exp = tadd(t, 64'h10, r - l - 1);
      chk("R3 value after wrap", 64'(d), 64'(exp[31:0]));
      brd(0, 2'd1, d, e);
      chk("R3 high after wrap", 64'(d), 64'(exp[63:32]));

      // R4 zero increment freezes
      bwr(0, 2'd2, 32'h0, i);
      exp = tadd(t, 64'h10, i - l);
      brd(0, 2'd0, d, r); chk("R4 frozen first read", 64'(d), 64'(exp[31:0]));
      repeat (10) @(negedge clk);
      brd(0, 2'd0, d, r); chk("R4 frozen later read", 64'(d), 64'(exp[31:0]));
      chk("R3 no wrap while frozen", 64'(wcnt), 1);

      // R7 retune while running
      bwr(0, 2'd2, 32'h100, x);
      t = 64'h0000_0007_0000_1000;
      bwr(0, 2'd0, t[31:0], x);
      bwr(0, 2'd1, t[63:32], l);
      repeat (4) @(negedge clk);
      bwr(0, 2'd2, 32'h3, i2);
      repeat (5) @(negedge clk);
      brd(0, 2'd0, d, r);
      exp = t + 64'h100 * 64'(i2 - l) + 64'h3 * 64'(r - i2 - 1);
      chk("R7 retune without restart", 64'(d), 64'(exp[31:0]));

      // R9 spare address
      bwr(0, 2'd3, 32'hFFFF_FFFF, x);
      brd(0, 2'd3, d, e); chk("R9 spare reads zero", 64'(d), 0);
      brd(0, 2'd2, d, e); chk("R9 spare write leaves increment", 64'(d), 64'h3);
      brd(0, 2'd0, d, r);
      exp = t + 64'h100 * 64'(i2 - l) + 64'h3 * 64'(r - i2 - 1);
      chk("R9 spare write leaves time", 64'(d), 64'(exp[31:0]));

      // R6 read data holds
      repeat (4) @(negedge clk);
      chk("R6 read data held", 64'(rdata0), 64'(d));

      // R1 bit 31 of wide increment, R5 zero load
      bwr(0, 2'd2, 32'hFFFF_FFFF, x);
      brd(0, 2'd2, d, e); chk("R1 bit 31 reads zero", 64'(d), 64'h7FFF_FFFF);
      bwr(0, 2'd0, 32'h0, x);
      bwr(0, 2'd1, 32'h0, l);
      brd(0, 2'd0, d, r); chk("R5 zero write clears", 64'(d), 0);
      repeat (2) @(negedge clk);
      brd(0, 2'd0, d, r);
      exp = tadd(0, 64'h7FFF_FFFF, r - l - 1);
      chk("R1 bit 31 not added low", 64'(d), 64'(exp[31:0]));
      brd(0, 2'd1, d, e);
      chk("R1 bit 31 not added high", 64'(d), 64'(exp[63:32]));

      // R2 narrow period three
      bwr(1, 2'd2, {8'd3, 24'h000100}, x);
      brd(1, 2'd2, d, e); chk("R2 narrow increment readback", 64'(d), 64'h0300_0100);
      t = 64'h0000_0002_0000_0055;
      bwr(1, 2'd0, t[31:0], x);
      bwr(1, 2'd1, t[63:32], l);
      repeat (10) @(negedge clk);
      brd(1, 2'd0, d, r);
      exp = t + 64'h100 * 64'((r - l - 1) / 3);
      chk("R2 narrow period three low", 64'(d), 64'(exp[31:0]));
      brd(1, 2'd1, d, e);
      chk("R2 narrow period three high", 64'(d), 64'(exp[63:32]));
      repeat (1) @(negedge clk);
      brd(1, 2'd0, d, r2);
      exp = t + 64'h100 * 64'((r2 - l - 1) / 3);
      chk("R2 narrow period three later", 64'(d), 64'(exp[31:0]));

      // R2 narrow period zero stops the count
      bwr(1, 2'd2, {8'd0, 24'h000005}, x);
      bwr(1, 2'd0, 32'h77, x);
      bwr(1, 2'd1, 32'h0, l);
      repeat (6) @(negedge clk);
      brd(1, 2'd0, d, r); chk("R2 narrow period zero", 64'(d), 64'h77);
      chk("R3 narrow no wrap", 64'(wrap1), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule